// File: doc/BRIEF.md
# Status Packet Transmitter

This block keeps watch over a status vector and reports it to a downstream collector as a short byte-serial packet. A one-byte configuration write chooses when reports are due and sets a 6-bit sequence number that travels with them. When a report is due, the block takes a copy of the status and of the sequence number. It raises a request output and shows its own address byte on the byte bus until the collector acknowledges that byte. After the acknowledge, the remaining bytes follow on consecutive clocks. The bus then returns to zero.

The packet starts with the address byte. Next comes a header byte that joins the sequence number to the two lowest status bits. The packet ends with as many data bytes as the payload width needs, each carrying eight further status bits. The payload width is a parameter from 3 to 26 bits, so a packet is three to five bytes long. There are four reporting modes: off, a single report, a report whenever the status changes, and a single report followed by change-driven reporting.

Top module: `stat_pkt_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pkt_req` is 0 and `pkt_byte` is 0.
- R2: `cfg_data[7:6]` selects the mode. 0 is off, and no request is raised in it. 1 is single report: exactly one packet follows the write, and a later status change raises no further request.
- R3: A due report raises `pkt_req` on the clock edge after it becomes due. `pkt_req` stays high, with `pkt_byte` equal to the `ADDR_BYTE` parameter, until `pkt_ack` is sampled high.
- R4: On the clock after `pkt_ack` is sampled high with `pkt_req` high, `pkt_req` falls and `pkt_byte` shows the header byte. The header byte is the sequence number in bits 7:2 and status bits 1:0 in bits 1:0. The data bytes follow on the next consecutive clocks. A packet is 2 + ceil((PAYLOAD_BITS-2)/8) bytes long.
- R5: Data byte k (k = 0, 1, ...) carries status bits 2+8k up to 9+8k, with the lowest bit in bit 0. Bit positions at or above PAYLOAD_BITS read as 0.
- R6: The status is captured on the edge that raises `pkt_req`. A status change after that edge does not alter the packet in flight.
- R7: In mode 2, a request is raised whenever the block is idle and the status differs from the value carried by the last packet. An unchanged status raises none. A change that happens during a packet is reported after that packet ends.
- R8: Mode 3 sends one packet and then behaves as mode 2, taking the value it just reported as the last one sent.
- R9: `pkt_byte` is 0 whenever no request is pending and no packet byte is being sent. `pkt_ack` has no effect while `pkt_req` is low.
- R10: The header carries the sequence number from the most recent configuration write before the request was raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe, one clock per write |
| cfg_data | input | 8 | Configuration byte: mode in bits 7:6, sequence number in bits 5:0 |
| stat_in | input | PAYLOAD_BITS | Status vector to report |
| pkt_ack | input | 1 | Collector has taken the address byte |
| pkt_req | output | 1 | A packet is waiting for the collector |
| pkt_byte | output | 8 | Packet byte bus, 0 when idle |

## Verification
The bench drives packets under all four modes and compares every byte with values it computes itself. Each internal fault has its own sign at the ports. A sequencer that loses its place sends too many or too few bytes, or leaves a non-zero byte on the bus the clock after the last data byte. A snapshot that tears shows the later status value one clock after the acknowledge. A wrong mode register or a stale last-sent value shows up as an extra or a missing request within one or two clocks of a configuration write or a status change.

// File: rtl/stpk_pkg.sv
package stpk_pkg;

  localparam int MAX_PAYLOAD = 26;
  localparam int SEQ_W       = 6;

  typedef enum logic [1:0] {
    MODE_OFF       = 2'd0,
    MODE_ONCE      = 2'd1,
    MODE_AUTO      = 2'd2,
    MODE_ONCE_AUTO = 2'd3
  } rpt_mode_e;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_REQ  = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  // number of data bytes after the header for a given payload width
  function automatic int data_bytes(int payload);
    return (payload - 2 + 7) / 8;
  endfunction

  // header byte: sequence number above the two lowest status bits
  function automatic logic [7:0] head_byte(logic [SEQ_W-1:0] seq, logic [1:0] low);
    return {seq, low};
  endfunction

  // data byte number idx (0-based) from a zero-padded status copy
  function automatic logic [7:0] body_byte(logic [MAX_PAYLOAD-1:0] snap, int idx);
    logic [MAX_PAYLOAD+7:0] wide;
    wide = {8'b0, snap};
    wide = wide >> (2 + 8 * idx);
    return wide[7:0];
  endfunction

endpackage

// File: rtl/stpk_cfg.sv
module stpk_cfg
  import stpk_pkg::*;
#(
  parameter int PAYLOAD_BITS = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [7:0]              cfg_data,
  input  logic [PAYLOAD_BITS-1:0] stat_in,
  input  logic                    capture,
  output logic                    due,
  output logic [SEQ_W-1:0]        seq
);

  rpt_mode_e               mode_q;
  logic [SEQ_W-1:0]        seq_q;
  logic                    once_pend_q;
  logic [PAYLOAD_BITS-1:0] last_sent_q;

  // named events for checks and readability
  logic stat_changed;
  logic auto_armed;
  logic wr_wants_once;

  assign stat_changed  = (stat_in != last_sent_q);
  assign auto_armed    = (mode_q == MODE_AUTO);
  assign wr_wants_once = (cfg_data[7:6] == MODE_ONCE) || (cfg_data[7:6] == MODE_ONCE_AUTO);

  assign due = once_pend_q || (auto_armed && stat_changed);
  assign seq = seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_OFF;
      seq_q       <= '0;
      once_pend_q <= 1'b0;
      last_sent_q <= '0;
    end else begin
      if (capture) begin
        last_sent_q <= stat_in;
        once_pend_q <= 1'b0;
        if (mode_q == MODE_ONCE_AUTO) mode_q <= MODE_AUTO;
      end
      // a write in the same cycle overrides the capture bookkeeping
      if (cfg_we) begin
        mode_q      <= rpt_mode_e'(cfg_data[7:6]);
        seq_q       <= cfg_data[SEQ_W-1:0];
        once_pend_q <= wr_wants_once;
      end
    end
  end

  // R2: off mode never produces a due report
  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF) |-> !due);

  // R8: after the single report of mode 3 the block is in change-driven mode
  assert_once_then_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !cfg_we && mode_q == MODE_ONCE_AUTO) |=> (mode_q == MODE_AUTO));

  // R7: a capture records the reported value, so the change flag clears
  assert_capture_clears_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !cfg_we && $stable(stat_in)) |=> !stat_changed || !$stable(stat_in));

endmodule

// File: rtl/stpk_tx.sv
module stpk_tx
  import stpk_pkg::*;
#(
  parameter int          PAYLOAD_BITS = 15,
  parameter logic [7:0]  ADDR_BYTE    = 8'hA5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    due,
  input  logic [SEQ_W-1:0]        seq,
  input  logic [PAYLOAD_BITS-1:0] stat_in,
  input  logic                    pkt_ack,
  output logic                    capture,
  output logic                    pkt_req,
  output logic [7:0]              pkt_byte
);

  localparam int ND    = data_bytes(PAYLOAD_BITS);
  localparam int IDX_W = $clog2(ND + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ND);

  tx_state_e               state_q;
  logic [IDX_W-1:0]        idx_q;
  logic [PAYLOAD_BITS-1:0] snap_stat_q;
  logic [SEQ_W-1:0]        snap_seq_q;
  logic [MAX_PAYLOAD-1:0]  snap_wide;

  // named events
  logic sending;
  logic in_flight;
  logic acked;
  logic last_byte;

  assign sending   = (state_q == TX_SEND);
  assign in_flight = (state_q != TX_IDLE);
  assign acked     = (state_q == TX_REQ) && pkt_ack;
  assign last_byte = sending && (idx_q == LAST_IDX);
  assign capture   = (state_q == TX_IDLE) && due;
  assign pkt_req   = (state_q == TX_REQ);

  always_comb begin
    snap_wide = '0;
    snap_wide[PAYLOAD_BITS-1:0] = snap_stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= TX_IDLE;
      idx_q       <= '0;
      snap_stat_q <= '0;
      snap_seq_q  <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (capture) begin
          state_q     <= TX_REQ;
          snap_stat_q <= stat_in;
          snap_seq_q  <= seq;
        end
        TX_REQ: if (acked) begin
          state_q <= TX_SEND;
          idx_q   <= '0;
        end
        TX_SEND: begin
          if (last_byte) state_q <= TX_IDLE;
          else           idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    pkt_byte = 8'h00;
    unique case (state_q)
      TX_REQ:  pkt_byte = ADDR_BYTE;
      TX_SEND: pkt_byte = (idx_q == '0) ? head_byte(snap_seq_q, snap_stat_q[1:0])
                                        : body_byte(snap_wide, int'(idx_q) - 1);
      default: pkt_byte = 8'h00;
    endcase
  end

  // R3: request and address byte persist until acknowledged
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_req && !pkt_ack) |=> (pkt_req && pkt_byte == ADDR_BYTE));

  // R4: acknowledge drops the request and brings up the header next clock
  assert_head_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_req && pkt_ack) |=> (!pkt_req && pkt_byte[1:0] == snap_stat_q[1:0]));

  // R4: the packet ends after the last data byte
  assert_packet_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> !sending);

  // R6: a request rising carries the status present at that edge
  assert_capture_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_req) |-> (snap_stat_q == $past(stat_in)));

  // R6: the copy does not move while a packet is in flight
  assert_snap_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |=> $stable(snap_stat_q));

  // R9: quiet bus when nothing is pending or being sent
  assert_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_req && !sending) |-> (pkt_byte == 8'h00));

endmodule

// File: rtl/stat_pkt_gen.sv
module stat_pkt_gen
  import stpk_pkg::*;
#(
  parameter int          PAYLOAD_BITS = 15,
  parameter logic [7:0]  ADDR_BYTE    = 8'hA5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [7:0]              cfg_data,
  input  logic [PAYLOAD_BITS-1:0] stat_in,
  input  logic                    pkt_ack,
  output logic                    pkt_req,
  output logic [7:0]              pkt_byte
);

  logic             due;
  logic             capture;
  logic [SEQ_W-1:0] seq;

  stpk_cfg #(
    .PAYLOAD_BITS(PAYLOAD_BITS)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_data (cfg_data),
    .stat_in  (stat_in),
    .capture  (capture),
    .due      (due),
    .seq      (seq)
  );

  stpk_tx #(
    .PAYLOAD_BITS(PAYLOAD_BITS),
    .ADDR_BYTE   (ADDR_BYTE)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .due      (due),
    .seq      (seq),
    .stat_in  (stat_in),
    .pkt_ack  (pkt_ack),
    .capture  (capture),
    .pkt_req  (pkt_req),
    .pkt_byte (pkt_byte)
  );

  // R1: nothing on the bus and no request in the first cycle after reset
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pkt_req && pkt_byte == 8'h00));

endmodule

// File: tb/tb_stat_pkt_gen.sv
module tb_stat_pkt_gen;

  localparam int         PB   = 15;
  localparam logic [7:0] ADDR = 8'hA5;
  localparam int         NDB  = (PB - 2 + 7) / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_data = '0;
  logic [PB-1:0] stat_in = '0;
  logic          pkt_ack = 1'b0;
  logic          pkt_req;
  logic [7:0]    pkt_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stat_pkt_gen #(.PAYLOAD_BITS(PB), .ADDR_BYTE(ADDR)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .stat_in(stat_in), .pkt_ack(pkt_ack), .pkt_req(pkt_req), .pkt_byte(pkt_byte)
  );

  // {seq[5:0], status[14:0]}
  localparam logic [20:0] VEC [6] = '{
    {6'd1,  15'h0000}, {6'd63, 15'h7FFF}, {6'd22, 15'h1234},
    {6'd40, 15'h4003}, {6'd7,  15'h03FC}, {6'd33, 15'h5A5A}
  };

  function automatic logic [7:0] exp_data(logic [PB-1:0] s, int k);
    longint v;
    v = longint'(s) / (longint'(1) << (2 + 8 * k));
    return 8'(v % 256);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(logic [1:0] mode, logic [5:0] seq);
    cfg_we = 1'b1;
    cfg_data = {mode, seq};
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_data = '0;
  endtask

  task automatic quiet(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({tag, " no request"}, 32'(pkt_req), 0);
      chk({tag, " bus zero"}, 32'(pkt_byte), 0);
    end
  endtask

  // receive one packet; after_stat is driven once the request is seen
  task automatic rx_packet(logic [PB-1:0] exp_stat, logic [5:0] exp_seq,
                           int delay, logic [PB-1:0] after_stat);
    int n = 0;
    while (!pkt_req && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk("R3 request raised", 32'(pkt_req), 1);
    chk("R3 address byte", 32'(pkt_byte), 32'(ADDR));
    stat_in = after_stat;
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      chk("R3 request held", 32'(pkt_req), 1);
      chk("R3 address held", 32'(pkt_byte), 32'(ADDR));
    end
    pkt_ack = 1'b1;
    @(negedge clk);
    pkt_ack = 1'b0;
    chk("R4 request drops", 32'(pkt_req), 0);
    chk("R10 R4 header byte", 32'(pkt_byte), 32'({exp_seq, exp_stat[1:0]}));
    for (int k = 0; k < NDB; k++) begin
      @(negedge clk);
      chk("R5 R6 data byte", 32'(pkt_byte), 32'(exp_data(exp_stat, k)));
    end
    @(negedge clk);
    chk("R9 bus zero after packet", 32'(pkt_byte), 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 request in reset", 32'(pkt_req), 0);
    chk("R1 bus in reset", 32'(pkt_byte), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 request after reset", 32'(pkt_req), 0);
    chk("R1 bus after reset", 32'(pkt_byte), 0);

    // table walk: single-report mode (R2) with varying sequence and status
    for (int i = 0; i < 6; i++) begin
      stat_in = VEC[i][PB-1:0];
      write_cfg(2'd1, VEC[i][20:15]);
      rx_packet(VEC[i][PB-1:0], VEC[i][20:15], i % 3, VEC[i][PB-1:0]);
    end

    // R2: single report does not repeat on a change
    stat_in = 15'h1111;
    quiet(6, "R2 once mode");

    // R2 off mode, R9 stray acknowledge ignored
    write_cfg(2'd0, 6'd12);
    stat_in = 15'h2222;
    quiet(4, "R2 off mode");
    pkt_ack = 1'b1;
    @(negedge clk);
    pkt_ack = 1'b0;
    chk("R9 ack ignored request", 32'(pkt_req), 0);
    chk("R9 ack ignored bus", 32'(pkt_byte), 0);
    quiet(3, "R9 after stray ack");

    // R6: status changes after the request edge do not tear the packet
    stat_in = 15'h6A5C;
    write_cfg(2'd1, 6'd5);
    rx_packet(15'h6A5C, 6'd5, 2, 15'h1F0F);

    // R7: auto mode reports the differing value, then stays quiet
    write_cfg(2'd2, 6'd9);
    rx_packet(15'h1F0F, 6'd9, 0, 15'h1F0F);
    quiet(6, "R7 unchanged status");
    stat_in = 15'h0C30;
    rx_packet(15'h0C30, 6'd9, 1, 15'h7001);
    // R7: change during the packet is reported afterwards
    rx_packet(15'h7001, 6'd9, 0, 15'h7001);
    quiet(4, "R7 settled");

    // R8: once then auto
    write_cfg(2'd0, 6'd0);
    stat_in = 15'h3333;
    quiet(2, "R8 pre");
    write_cfg(2'd3, 6'd3);
    rx_packet(15'h3333, 6'd3, 0, 15'h3333);
    quiet(6, "R8 no repeat");
    stat_in = 15'h4444;
    rx_packet(15'h4444, 6'd3, 0, 15'h4444);

    write_cfg(2'd0, 6'd0);
    quiet(2, "R2 final off");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule